// File: doc/BRIEF.md
# Nibble ECC Fuse Encoder

This block sits in front of a one-time-programmable storage array and turns a stream of data bytes into ECC-protected code bytes ready to be burned. Each 4-bit half of a source byte becomes one 8-bit code byte. The nibble is kept as-is in the lower half and four parity bits, each the XOR of one pair of data bits, fill the upper half. Every source byte therefore produces two array bytes: the code for its low nibble first, then the code for its high nibble at the next address.

A job is started with a base byte offset into the array and a source byte count. Source bytes then arrive on a valid/ready handshake. The encoder produces a write stream of code bytes at consecutive array addresses starting from the base. It takes one source byte every two cycles, and holds ready low while the high-nibble code is being written. When the last code byte has been written, a one-cycle done pulse follows. A job whose code bytes would run past the last array address is refused at start with a one-cycle error pulse, and nothing is written. Wider values such as 32-bit words are supplied least-significant byte first, so their lowest nibble lands at the base address.

Top module: `fuse_nibble_encoder`

## Requirements
- R1: Bits 3:0 of every code byte written equal the source nibble it encodes, unchanged.
- R2: With nibble bits d0..d3, code bit 4 is d0^d1, bit 5 is d2^d3, bit 6 is d0^d2 and bit 7 is d1^d3.
- R3: The low-nibble code of a source byte is written the cycle after its handshake, and the high-nibble code the cycle after that at the next address. A job writes base, base+1, base+2 and so on in order.
- R4: A job of N source bytes performs exactly 2N writes. A word fed least-significant byte first places the code of its bits 3:0 at the base address.
- R5: in_ready is high only while the encoder waits for a source byte. It is low when no job runs and in the cycle after every accepted byte, while the high-nibble code is written.
- R6: done pulses for exactly one cycle, the cycle after the last code byte is written. A job with a byte count of zero gives one done pulse and no writes.
- R7: If base + 2*count exceeds 1024 (the array size, 2^ADDR_W), start is refused: err is high for the one cycle after start is sampled, and there are no writes, no done and no busy. A job ending exactly at address 1023 is accepted.
- R8: A start pulse while a job is running is ignored: the running job's addresses are unchanged and no error is raised.
- R9: After reset, in_ready, busy, wr_en, done and err are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a job; sampled only when idle |
| start_base | input | ADDR_W | First array byte address of the job |
| start_count | input | CNT_W | Number of source bytes in the job |
| in_valid | input | 1 | Source byte present |
| in_data | input | 8 | Source byte |
| in_ready | output | 1 | Encoder accepts a source byte this cycle |
| busy | output | 1 | A job is in progress |
| wr_en | output | 1 | Code byte write strobe |
| wr_addr | output | ADDR_W | Array byte address of the write |
| wr_data | output | 8 | Code byte to write |
| done | output | 1 | One-cycle pulse after the last write of a job |
| err | output | 1 | One-cycle pulse when a start is refused for overflow |

## Verification
The bench builds the encoder with its default widths: a 10-bit address and a 10-bit byte count. With these widths the true end of a 1024-byte array can be reached in a few dozen cycles. A job that ends exactly at address 1023 and a job one source byte longer that must be refused both fall within a short run. The 10-bit count also lets a count of zero and a start raised during a running job be driven directly. One eight-byte job covers all sixteen nibble values, so every parity combination is compared.

// File: rtl/fne_pkg.sv
// Shared constants, state encoding and parity wiring for the nibble ECC
// fuse encoder. Assumes a fixed 4-data / 4-parity code per nibble.
package fne_pkg;
    localparam int NIB_W     = 4;
    localparam int PAR_W     = 4;
    localparam int CODE_W    = NIB_W + PAR_W;
    localparam int NIB_PER_B = 2;
    localparam int BYTE_W    = NIB_W * NIB_PER_B;

    typedef enum logic [1:0] {
        FSM_IDLE = 2'd0,
        FSM_LOW  = 2'd1,
        FSM_HIGH = 2'd2,
        FSM_FIN  = 2'd3
    } fne_state_e;

    // First data bit feeding parity bit k (code bit NIB_W+k)
    function automatic int par_src_a(input int k);
        case (k)
            0:       return 0;
            1:       return 2;
            2:       return 0;
            default: return 1;
        endcase
    endfunction

    // Second data bit feeding parity bit k
    function automatic int par_src_b(input int k);
        case (k)
            0:       return 1;
            1:       return 3;
            2:       return 2;
            default: return 3;
        endcase
    endfunction
endpackage

// File: rtl/fne_nibble_code.sv
// Combinational encoder for one nibble: data passes through in the low bits,
// each parity bit is the XOR of a pair of data bits chosen in fne_pkg.
// Assumes nothing about timing; purely combinational.
module fne_nibble_code
    import fne_pkg::*;
(
    input  logic [NIB_W-1:0]  nib_i,
    output logic [CODE_W-1:0] code_o
);
    // Data bits are stored unchanged
    assign code_o[NIB_W-1:0] = nib_i;

    // One pairwise XOR per parity bit
    for (genvar k = 0; k < PAR_W; k++) begin : g_par
        localparam int SA = par_src_a(k);
        localparam int SB = par_src_b(k);
        assign code_o[NIB_W+k] = nib_i[SA] ^ nib_i[SB];
    end
endmodule

// File: rtl/fne_addr_seq.sv
// Address and remaining-count tracker for one job, plus the range check
// made at start. Assumes load and advance are never raised together.
module fne_addr_seq #(
    parameter int ADDR_W = 10,
    parameter int CNT_W  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              advance_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic [CNT_W-1:0]  count_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              last_o,
    output logic              fits_o,
    output logic              zero_o
);
    localparam int SUM_W = ((ADDR_W > CNT_W + 1) ? ADDR_W : CNT_W + 1) + 1;
    localparam logic [SUM_W-1:0] SPAN = (SUM_W)'(1) << ADDR_W;

    logic [ADDR_W-1:0] addr_q;
    logic [CNT_W-1:0]  rem_q;
    logic [SUM_W-1:0]  end_excl;

    // Exclusive end address of the requested job, never truncated
    assign end_excl = SUM_W'(base_i) + (SUM_W'(count_i) << 1);
    assign fits_o   = (end_excl <= SPAN);
    assign zero_o   = (count_i == '0);
    assign last_o   = (rem_q == CNT_W'(1));
    assign addr_o   = addr_q;

    // Load at job start, then step by one source byte (two array bytes)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            rem_q  <= '0;
        end else if (load_i) begin
            addr_q <= base_i;
            rem_q  <= count_i;
        end else if (advance_i) begin
            addr_q <= addr_q + ADDR_W'(2);
            rem_q  <= rem_q - CNT_W'(1);
        end
    end
endmodule

// File: rtl/fne_ctrl.sv
// Job sequencer: waits for start, alternates between taking a source byte
// and emitting its high nibble, then flags completion. Assumes the range
// check and remaining-count status come from fne_addr_seq.
module fne_ctrl
    import fne_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       fits_i,
    input  logic       zero_i,
    input  logic       in_valid_i,
    input  logic       last_i,
    output fne_state_e state_o,
    output logic       in_ready_o,
    output logic       load_o,
    output logic       reject_o,
    output logic       accept_o,
    output logic       advance_o,
    output logic       finish_o
);
    fne_state_e state_q, state_d;
    logic       idle;

    // Decode control strobes from the current state
    always_comb begin
        idle       = (state_q == FSM_IDLE);
        load_o     = idle && start_i && fits_i;
        reject_o   = idle && start_i && !fits_i;
        in_ready_o = (state_q == FSM_LOW);
        accept_o   = in_ready_o && in_valid_i;
        advance_o  = (state_q == FSM_HIGH);
        finish_o   = (state_q == FSM_FIN);
    end

    // Next-state selection
    always_comb begin
        state_d = state_q;
        case (state_q)
            FSM_IDLE: if (load_o) state_d = zero_i ? FSM_FIN : FSM_LOW;
            FSM_LOW:  if (accept_o) state_d = FSM_HIGH;
            FSM_HIGH: state_d = last_i ? FSM_FIN : FSM_LOW;
            default:  state_d = FSM_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= FSM_IDLE;
        else        state_q <= state_d;
    end

    assign state_o = state_q;
endmodule

// File: rtl/fuse_nibble_encoder.sv
// Streaming nibble ECC encoder for a one-time-programmable array. Each
// accepted byte yields two registered code-byte writes, low nibble first,
// at consecutive addresses from the job base; done follows the last write.
// Assumes the array has 2^ADDR_W byte locations.
module fuse_nibble_encoder
    import fne_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int CNT_W  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_base,
    input  logic [CNT_W-1:0]  start_count,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_data,
    output logic              in_ready,
    output logic              busy,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [CODE_W-1:0] wr_data,
    output logic              done,
    output logic              err
);
    fne_state_e        state;
    logic              load, reject, accept, advance, finish;
    logic              fits, zero, last;
    logic [ADDR_W-1:0] addr_cur;
    logic [NIB_W-1:0]  hi_q;
    logic [NIB_W-1:0]  enc_nib;
    logic [CODE_W-1:0] enc_code;
    logic              wr_en_q, done_q, err_q;
    logic [ADDR_W-1:0] wr_addr_q;
    logic [CODE_W-1:0] wr_data_q;

    fne_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start),
        .fits_i    (fits),
        .zero_i    (zero),
        .in_valid_i(in_valid),
        .last_i    (last),
        .state_o   (state),
        .in_ready_o(in_ready),
        .load_o    (load),
        .reject_o  (reject),
        .accept_o  (accept),
        .advance_o (advance),
        .finish_o  (finish)
    );

    fne_addr_seq #(
        .ADDR_W(ADDR_W),
        .CNT_W (CNT_W)
    ) u_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (load),
        .advance_i(advance),
        .base_i   (start_base),
        .count_i  (start_count),
        .addr_o   (addr_cur),
        .last_o   (last),
        .fits_o   (fits),
        .zero_o   (zero)
    );

    // One shared encoder: the live low nibble, or the held high nibble
    assign enc_nib = advance ? hi_q : in_data[NIB_W-1:0];

    fne_nibble_code u_code (
        .nib_i (enc_nib),
        .code_o(enc_code)
    );

    // Keep the high nibble of the accepted byte for the following cycle
    always_ff @(posedge clk) begin
        if (!rst_n)      hi_q <= '0;
        else if (accept) hi_q <= in_data[BYTE_W-1:NIB_W];
    end

    // Registered write port and status pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_en_q   <= 1'b0;
            wr_addr_q <= '0;
            wr_data_q <= '0;
            done_q    <= 1'b0;
            err_q     <= 1'b0;
        end else begin
            wr_en_q <= accept || advance;
            done_q  <= finish;
            err_q   <= reject;
            if (accept) begin
                wr_addr_q <= addr_cur;
                wr_data_q <= enc_code;
            end else if (advance) begin
                wr_addr_q <= addr_cur + ADDR_W'(1);
                wr_data_q <= enc_code;
            end
        end
    end

    assign busy    = (state != FSM_IDLE);
    assign wr_en   = wr_en_q;
    assign wr_addr = wr_addr_q;
    assign wr_data = wr_data_q;
    assign done    = done_q;
    assign err     = err_q;
endmodule

// File: rtl/fne_checker.sv
// Protocol checker for fuse_nibble_encoder, observing its ports only.
// Assumes a synchronous active-low reset.
module fne_checker #(
    parameter int ADDR_W = 10,
    parameter int CNT_W  = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [ADDR_W-1:0] start_base,
    input logic [CNT_W-1:0]  start_count,
    input logic              in_valid,
    input logic [7:0]        in_data,
    input logic              in_ready,
    input logic              busy,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [7:0]        wr_data,
    input logic              done,
    input logic              err
);
    a_r2_parity_bits: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_data[4] == (wr_data[0] ^ wr_data[1])) &&
                  (wr_data[5] == (wr_data[2] ^ wr_data[3])) &&
                  (wr_data[6] == (wr_data[0] ^ wr_data[2])) &&
                  (wr_data[7] == (wr_data[1] ^ wr_data[3])));

    a_r1_low_nibble_first: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> (wr_en && wr_data[3:0] == $past(in_data[3:0])));

    a_r3_high_next_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> ##1 (wr_en &&
            wr_data[3:0] == $past(in_data[7:4], 2) &&
            wr_addr == ADDR_W'($past(wr_addr) + 1'b1)));

    a_r5_stall_after_take: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !in_ready);

    a_r5_ready_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> busy);

    a_r6_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!wr_en && !err && $past(busy)));

    a_r7_err_no_job: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (!busy && !wr_en && $past(start)));
endmodule

bind fuse_nibble_encoder fne_checker #(
    .ADDR_W(ADDR_W),
    .CNT_W (CNT_W)
) u_fne_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .start_base (start_base),
    .start_count(start_count),
    .in_valid   (in_valid),
    .in_data    (in_data),
    .in_ready   (in_ready),
    .busy       (busy),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .done       (done),
    .err        (err)
);

// File: tb/fuse_nibble_encoder_bench.sv
`timescale 1ns/1ps
module fuse_nibble_encoder_bench;
    localparam int AW = 10;
    localparam int CW = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] start_base = '0;
    logic [CW-1:0] start_count = '0;
    logic          in_valid = 1'b0;
    logic [7:0]    in_data = '0;
    logic          in_ready, busy, wr_en, done, err;
    logic [AW-1:0] wr_addr;
    logic [7:0]    wr_data;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    int wr_cnt = 0;
    int done_cnt = 0;
    int err_cnt = 0;
    int stall_viol = 0;
    int done_cyc = 0;
    logic hs_edge = 1'b0;
    logic [AW-1:0] log_addr [0:127];
    logic [7:0]    log_data [0:127];
    int            log_cyc  [0:127];
    logic [7:0]    jb [0:15];

    fuse_nibble_encoder #(.ADDR_W(AW), .CNT_W(CW)) u_fuse_nibble_encoder (
        .clk(clk), .rst_n(rst_n), .start(start), .start_base(start_base),
        .start_count(start_count), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .busy(busy), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .done(done), .err(err)
    );

    always #2.5 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        hs_edge <= in_valid && in_ready;
    end

    // Observe outputs away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (wr_en && wr_cnt < 128) begin
                log_addr[wr_cnt] = wr_addr;
                log_data[wr_cnt] = wr_data;
                log_cyc[wr_cnt]  = cyc;
                wr_cnt++;
            end
            if (done) begin done_cnt++; done_cyc = cyc; end
            if (err) err_cnt++;
            if (hs_edge && in_ready) stall_viol++;
        end
    end

    function automatic logic [7:0] exp_code(input logic [3:0] n);
        return {n[1] ^ n[3], n[0] ^ n[2], n[2] ^ n[3], n[0] ^ n[1], n};
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic start_job(input int base, input int count);
        @(negedge clk);
        start = 1'b1; start_base = AW'(base); start_count = CW'(count);
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b, input int gap);
        repeat (gap) @(negedge clk);
        in_valid = 1'b1; in_data = b;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic wait_done(input int d0);
        int n = 0;
        while (done_cnt == d0 && n < 100) begin @(negedge clk); n++; end
        @(negedge clk);
    endtask

    // Compare a whole job's writes against the bytes in jb
    task automatic check_stream(input int w0, input int d0, input int base, input int nb);
        chk(wr_cnt - w0 == 2 * nb, "R4 write count", wr_cnt - w0, 2 * nb);
        for (int i = 0; i < nb; i++) begin
            for (int h = 0; h < 2; h++) begin
                int idx = w0 + 2 * i + h;
                logic [3:0] nib = h ? jb[i][7:4] : jb[i][3:0];
                chk(log_data[idx][3:0] == nib, "R1 data nibble", log_data[idx], nib);
                chk(log_data[idx] == exp_code(nib), "R2 code byte", log_data[idx], exp_code(nib));
                chk(log_addr[idx] == AW'(base + 2 * i + h), "R3 address", log_addr[idx], base + 2 * i + h);
            end
            chk(log_cyc[w0 + 2 * i + 1] == log_cyc[w0 + 2 * i] + 1, "R3 high follows low",
                log_cyc[w0 + 2 * i + 1], log_cyc[w0 + 2 * i] + 1);
        end
        chk(done_cnt - d0 == 1, "R6 done count", done_cnt - d0, 1);
        if (nb > 0)
            chk(done_cyc == log_cyc[wr_cnt - 1] + 1, "R6 done timing", done_cyc, log_cyc[wr_cnt - 1] + 1);
    endtask

    task automatic t_reset();
        chk(!in_ready && !busy && !wr_en && !done && !err, "R9 reset state",
            {in_ready, busy, wr_en, done, err}, 0);
    endtask

    task automatic t_all_nibbles();
        int w0 = wr_cnt, d0 = done_cnt, s0 = stall_viol;
        for (int i = 0; i < 8; i++) jb[i] = {4'(2 * i + 1), 4'(2 * i)};
        start_job(5, 8);
        for (int i = 0; i < 8; i++) send_byte(jb[i], 0);
        wait_done(d0);
        check_stream(w0, d0, 5, 8);
        chk(stall_viol == s0, "R5 stall after byte", stall_viol - s0, 0);
        chk(!in_ready && !busy, "R5 ready low when idle", {in_ready, busy}, 0);
    endtask

    task automatic t_word_lsb_first();
        int w0 = wr_cnt, d0 = done_cnt;
        logic [31:0] word = 32'h12345678;
        for (int i = 0; i < 4; i++) jb[i] = word[8 * i +: 8];
        start_job(64, 4);
        for (int i = 0; i < 4; i++) send_byte(jb[i], 2);
        wait_done(d0);
        chk(log_data[w0] == exp_code(4'h8), "R4 word lowest nibble at base", log_data[w0], exp_code(4'h8));
        check_stream(w0, d0, 64, 4);
    endtask

    task automatic t_exact_fit();
        int w0 = wr_cnt, d0 = done_cnt, e0 = err_cnt;
        for (int i = 0; i < 12; i++) jb[i] = 8'(i * 23 + 7);
        start_job(1000, 12);
        for (int i = 0; i < 12; i++) send_byte(jb[i], i % 2);
        wait_done(d0);
        chk(err_cnt == e0, "R7 exact fit not refused", err_cnt - e0, 0);
        chk(log_addr[wr_cnt - 1] == AW'(1023), "R7 last address 1023", log_addr[wr_cnt - 1], 1023);
        check_stream(w0, d0, 1000, 12);
    endtask

    task automatic t_overflow();
        int w0 = wr_cnt, d0 = done_cnt;
        @(negedge clk);
        start = 1'b1; start_base = AW'(1000); start_count = CW'(13);
        @(negedge clk);
        start = 1'b0;
        chk(err == 1'b1, "R7 err after start", err, 1);
        @(negedge clk);
        chk(err == 1'b0, "R7 err one cycle", err, 0);
        repeat (6) @(negedge clk);
        chk(!busy && !in_ready, "R7 stays idle", {busy, in_ready}, 0);
        chk(wr_cnt == w0 && done_cnt == d0, "R7 no writes no done", wr_cnt - w0, 0);
    endtask

    task automatic t_zero_count();
        int w0 = wr_cnt, d0 = done_cnt;
        start_job(3, 0);
        wait_done(d0);
        repeat (3) @(negedge clk);
        chk(done_cnt - d0 == 1, "R6 zero count done", done_cnt - d0, 1);
        chk(wr_cnt == w0, "R6 zero count no writes", wr_cnt - w0, 0);
    endtask

    task automatic t_start_while_busy();
        int w0 = wr_cnt, d0 = done_cnt, e0 = err_cnt;
        jb[0] = 8'hA5; jb[1] = 8'h3C;
        start_job(100, 2);
        send_byte(jb[0], 0);
        start_job(200, 1);
        send_byte(jb[1], 0);
        wait_done(d0);
        chk(err_cnt == e0, "R8 no error on busy start", err_cnt - e0, 0);
        check_stream(w0, d0, 100, 2);
        repeat (4) @(negedge clk);
        chk(done_cnt - d0 == 1 && !busy, "R8 no second job", done_cnt - d0, 1);
    endtask

    // Watchdog: a hung run is a failed check
    always @(posedge clk) begin
        if (cyc > 20000) begin
            checks++; fails++;
            $display("FAIL watchdog: actual=%0d expected=<20000 cycles", cyc);
            $display("Result: errors=%0d of %0d checks", fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_all_nibbles();
        t_word_lsb_first();
        t_exact_fit();
        t_overflow();
        t_zero_count();
        t_start_while_busy();
        $display("Result: errors=%0d of %0d checks", fails, checks);
        $finish;
    end
endmodule